// File: doc/BRIEF.md
# Masked Interrupt Vector Controller

This block gathers up to thirty level-sensitive interrupt lines and gates them with a mask that software writes. It then drives one interrupt-request wire and an 8-bit vector bus towards a processor core. When exactly one unmasked line is high, the vector names that line. When two or more are high, the vector is a single shared value. Software then reads the masked status word and decides which source to serve first. The block does no priority encoding in hardware.

Software reaches the block through a plain 32-bit register port. The port has an address, separate read and write strobes, an access-size code, write data and combinational read data. Software uses it to program the mask and to look at the live line levels and the gated levels. Two further words, a non-maskable status word and a debug status word, are kept as plain storage. The block itself neither sets nor consumes them.

Top module: `irqvec_ctrl`

## Requirements
- R1: Word offsets decode as follows: 0x00 mask, 0x04 live line levels, 0x08 gated levels, 0x0C non-maskable status word, 0x10 debug status word. Each must be word aligned (address bits 1:0 equal to 0).
- R2: A word read of offset 0x04 returns the current level of line i in bit i for i = 0..29, with bits 31:30 reading zero. A word write to 0x04 or to 0x08 changes nothing.
- R3: A word read of offset 0x08 returns the live levels ANDed with the mask. This holds in the same cycle that a line changes.
- R4: When exactly one gated bit is set, at index i, the request wire is high and the vector equals 0x31 + i.
- R5: When two or more gated bits are set, the request wire is high and the vector equals 0x30.
- R6: When no gated bit is set, the request wire is low and the vector equals 0x00.
- R7: The request wire and the vector are registered. After each rising clock edge they show the lines and the mask as they stood just before that edge.
- R8: Only an access with size code 2'b10 (32-bit) acts. For any other size code, reads return zero, writes change nothing, and no error is flagged.
- R9: A 32-bit read or write to an unaligned offset, or to an offset of 0x14 or above, raises bus_err in that same cycle. Such a read returns zero and such a write changes no register.
- R10: While rst_n is low at a rising edge, the mask, both status words, the request wire and the vector are all cleared to zero.
- R11: The two status words hold all 32 written bits and read them back unchanged. The mask holds bits 29:0, and its bits 31:30 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 30 | Level-sensitive interrupt lines, synchronous to clk |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 treated as narrow |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| bus_err | output | 1 | Single-cycle flag for a word access outside the map |
| cpu_irq | output | 1 | Interrupt request to the core |
| cpu_vec | output | 8 | Interrupt vector to the core |

## Verification
Several properties are checked by assertions on every cycle:
- the vector is zero whenever the request is low;
- the vector stays inside the shared-plus-per-line range;
- the request follows the previous cycle's gated lines;
- a single gated source never yields the shared vector;
- narrow or erroneous accesses leave all storage untouched.

Other behaviour only shows up in the bench's scenarios. This includes the exact per-line vector for the lowest and highest lines, a mask change moving the result from shared to single, writes to the read-only status offsets being dropped, and status-word readback. The bench compares read data, the error flag, the request and the vector against its own model on every clock.

// File: rtl/irqvec_pkg.sv
// Package: irqvec_pkg
// Shared constants, register selector type and address decode for the
// masked interrupt vector controller. Assumes a 32-bit data path and a
// 5-bit byte offset into the register window.
package irqvec_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int WORD_LSB  = 2;
    localparam int NUM_WORDS = 5;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_RAW    = 3'd1,
        SEL_GATED  = 3'd2,
        SEL_NMI    = 3'd3,
        SEL_DEBUG  = 3'd4,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // Turn a byte offset into a register selector; unaligned or past the window gives SEL_NONE
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        logic [ADDR_W-WORD_LSB-1:0] word;
        word = addr[ADDR_W-1:WORD_LSB];
        sel  = SEL_NONE;
        if (addr[WORD_LSB-1:0] == '0 && int'(word) < NUM_WORDS) begin
            case (word)
                3'd0:    sel = SEL_MASK;
                3'd1:    sel = SEL_RAW;
                3'd2:    sel = SEL_GATED;
                3'd3:    sel = SEL_NMI;
                3'd4:    sel = SEL_DEBUG;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/irqvec_regs.sv
// Module: irqvec_regs
// Register port of the controller. It holds the mask and the two plain status
// words, decodes word accesses, flags accesses outside the map and forms
// combinational read data. Live and gated levels are views, not storage,
// so writes to them are dropped. Assumes NUM_LINES < DATA_W.
module irqvec_regs
    import irqvec_pkg::*;
#(
    parameter int NUM_LINES = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  lines,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [1:0]            bus_size,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_err,
    output logic [NUM_LINES-1:0]  mask
);

    localparam int PAD_W = DATA_W - NUM_LINES;

    logic                 is_word;
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] mask_q;
    logic [DATA_W-1:0]    nmi_q;
    logic [DATA_W-1:0]    dbg_q;
    logic [DATA_W-1:0]    raw_view;
    logic [DATA_W-1:0]    gated_view;
    logic [DATA_W-1:0]    mask_view;

    // Classify the current access
    always_comb begin
        is_word = (bus_size == SIZE_WORD);
        sel     = decode_offset(bus_addr);
        bus_err = is_word && (bus_we || bus_re) && (sel == SEL_NONE);
    end

    // Zero-extend the line-wide views to the data width
    always_comb begin
        raw_view   = {{PAD_W{1'b0}}, lines};
        gated_view = {{PAD_W{1'b0}}, lines & mask_q};
        mask_view  = {{PAD_W{1'b0}}, mask_q};
    end

    // Storage for the mask and the two status words; only word writes act
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            nmi_q  <= '0;
            dbg_q  <= '0;
        end else if (bus_we && is_word) begin
            case (sel)
                SEL_MASK:  mask_q <= bus_wdata[NUM_LINES-1:0];
                SEL_NMI:   nmi_q  <= bus_wdata;
                SEL_DEBUG: dbg_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Read data multiplexer; zero for narrow reads, idle cycles and holes
    always_comb begin
        bus_rdata = '0;
        if (bus_re && is_word) begin
            case (sel)
                SEL_MASK:  bus_rdata = mask_view;
                SEL_RAW:   bus_rdata = raw_view;
                SEL_GATED: bus_rdata = gated_view;
                SEL_NMI:   bus_rdata = nmi_q;
                SEL_DEBUG: bus_rdata = dbg_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign mask = mask_q;

    // R8: narrow reads give zero
    a_r8_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !is_word) |-> (bus_rdata == '0));

    // R8: narrow writes leave storage alone
    a_r8_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !is_word) |=> ($stable(mask_q) && $stable(nmi_q) && $stable(dbg_q)));

    // R9: a flagged access changes nothing and reads zero
    a_r9_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> ($stable(mask_q) && $stable(nmi_q) && $stable(dbg_q)));

    a_r9_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    // R2: upper bits of the live view read zero
    a_r2_raw_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && is_word && sel == SEL_RAW) |-> (bus_rdata[DATA_W-1:NUM_LINES] == '0));

endmodule

// File: rtl/irqvec_encode.sv
// Module: irqvec_encode
// Pure combinational summary of the gated lines: whether any is set,
// whether more than one is set, and the index of the lowest set line.
// The index is meaningful only when exactly one line is set.
module irqvec_encode #(
    parameter int NUM_LINES = 30,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pend,
    output logic                 any,
    output logic                 multi,
    output logic [IDX_W-1:0]     idx
);

    // Any and multi flags: clearing the lowest set bit leaves something only when two or more are set
    always_comb begin
        any   = |pend;
        multi = |(pend & (pend - NUM_LINES'(1)));
    end

    // Lowest set index, scanned from the top so the lowest wins
    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irqvec_ctrl.sv
// Module: irqvec_ctrl
// Top of the masked interrupt vector controller. It gates the lines with the
// mask, summarises the result and registers the request and the vector for
// the core. Assumes the lines are already synchronous to clk.
module irqvec_ctrl
    import irqvec_pkg::*;
#(
    parameter int              NUM_LINES  = 30,
    parameter int              VEC_W      = 8,
    parameter logic [VEC_W-1:0] SHARED_VEC = 8'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [1:0]           bus_size,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic                 cpu_irq,
    output logic [VEC_W-1:0]     cpu_vec
);

    localparam int               IDX_W    = $clog2(NUM_LINES);
    localparam logic [VEC_W-1:0] BASE_VEC = SHARED_VEC + VEC_W'(1);
    localparam logic [VEC_W-1:0] LAST_VEC = SHARED_VEC + VEC_W'(NUM_LINES);

    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] pend;
    logic                 any;
    logic                 multi;
    logic [IDX_W-1:0]     idx;
    logic                 past_ok;

    irqvec_regs #(.NUM_LINES(NUM_LINES)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_lines),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .mask      (mask)
    );

    // Gate the live lines with the mask
    assign pend = irq_lines & mask;

    irqvec_encode #(.NUM_LINES(NUM_LINES)) i_encode (
        .pend  (pend),
        .any   (any),
        .multi (multi),
        .idx   (idx)
    );

    // Registered request and vector towards the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
            cpu_vec <= '0;
        end else begin
            cpu_irq <= any;
            if (!any)       cpu_vec <= '0;
            else if (multi) cpu_vec <= SHARED_VEC;
            else            cpu_vec <= BASE_VEC + VEC_W'(idx);
        end
    end

    // Marks that one clock has passed since reset, for $past checks
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6: no request means a zero vector
    a_r6_idle_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (cpu_vec == '0));

    // R4, R5: a raised request carries a vector from the defined range
    a_r5_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (cpu_vec >= SHARED_VEC && cpu_vec <= LAST_VEC));

    // R7: the request follows the gated lines of the previous cycle
    a_r7_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cpu_irq == $past(|pend)));

    // R4: a single gated source never gets the shared vector
    a_r4_single_not_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $countones($past(pend)) == 1) |-> (cpu_irq && cpu_vec != SHARED_VEC));

endmodule

// File: tb/test_irqvec_ctrl.sv
// Bench for irqvec_ctrl: behavioural model stepped each clock and compared
// on read data, error flag, request and vector every cycle.
module test_irqvec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] irq_lines = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        cpu_irq;
    logic [7:0]  cpu_vec;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [31:0] m_mask = '0;
    logic [31:0] m_nmi  = '0;
    logic [31:0] m_dbg  = '0;
    logic        m_irq  = 1'b0;
    logic [7:0]  m_vec  = '0;

    always #10 clk = ~clk;

    irqvec_ctrl i_irqvec_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
    );

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then step the model past the rising edge
    task automatic step(input logic [29:0] ln, input logic we, input logic re,
                        input logic [1:0] sz, input logic [4:0] ad, input logic [31:0] wd);
        logic        word;
        logic        inmap;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [31:0] gated;
        int          cnt;
        int          low;
        string       tag;
        @(negedge clk);
        irq_lines = ln; bus_we = we; bus_re = re; bus_size = sz; bus_addr = ad; bus_wdata = wd;
        #2;
        word    = (sz == 2'b10);
        inmap   = (ad[1:0] == 2'b00) && (ad < 5'h14);
        exp_err = word && (we || re) && !inmap;
        exp_rd  = '0;
        tag     = "R8";
        gated   = {2'b00, ln} & m_mask;
        if (word && !inmap) tag = "R9";
        if (re && word && inmap) begin
            case (ad)
                5'h00: begin exp_rd = m_mask;       tag = "R1"; end
                5'h04: begin exp_rd = {2'b00, ln};  tag = "R2"; end
                5'h08: begin exp_rd = gated;        tag = "R3"; end
                5'h0C: begin exp_rd = m_nmi;        tag = "R11"; end
                default: begin exp_rd = m_dbg;      tag = "R11"; end
            endcase
        end
        if (re) check(tag, "rdata", bus_rdata, exp_rd);
        check("R9", "bus_err", {31'b0, bus_err}, {31'b0, exp_err});
        // R7: registered outputs reflect the previous edge
        check(m_vec == 8'h00 ? "R6" : (m_vec == 8'h30 ? "R5" : "R4"), "cpu_vec", {24'b0, cpu_vec}, {24'b0, m_vec});
        check("R7", "cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
        @(posedge clk);
        #1;
        cnt = 0; low = -1;
        for (int i = 0; i < 30; i++) begin
            if (gated[i]) begin
                cnt++;
                if (low < 0) low = i;
            end
        end
        m_irq = (cnt != 0);
        m_vec = (cnt == 0) ? 8'h00 : (cnt > 1 ? 8'h30 : 8'(8'h31 + low));
        if (we && word && inmap) begin
            if (ad == 5'h00) m_mask = wd & 32'h3FFF_FFFF;
            if (ad == 5'h0C) m_nmi = wd;
            if (ad == 5'h10) m_dbg = wd;
        end
    endtask

    task automatic wr(input logic [29:0] ln, input logic [4:0] ad, input logic [31:0] wd);
        step(ln, 1'b1, 1'b0, 2'b10, ad, wd);
    endtask

    task automatic rd(input logic [29:0] ln, input logic [4:0] ad);
        step(ln, 1'b0, 1'b1, 2'b10, ad, 32'h0);
    endtask

    task automatic idle(input logic [29:0] ln);
        step(ln, 1'b0, 1'b0, 2'b10, 5'h00, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs cleared under reset
        check("R10", "cpu_irq reset", {31'b0, cpu_irq}, 32'h0);
        check("R10", "cpu_vec reset", {24'b0, cpu_vec}, 32'h0);
        rst_n = 1'b1;
        rd('0, 5'h00);                      // R10 mask cleared
        rd('0, 5'h0C);                      // R10 status cleared
        wr('0, 5'h00, 32'hFFFF_FFFF);       // R11 upper mask bits drop
        rd('0, 5'h00);
        // R4: single lines, lowest and highest
        idle(30'h0000_0020); idle(30'h0000_0020);
        idle(30'h0000_0001); idle(30'h0000_0001);
        idle(30'h2000_0000); idle(30'h2000_0000);
        // R5: several lines
        idle(30'h2000_0001); idle(30'h0000_0030); idle(30'h0000_0030);
        // R3: mask change moves shared to single
        wr(30'h0000_0030, 5'h00, 32'h0000_0010);
        rd(30'h0000_0030, 5'h08); idle(30'h0000_0030);
        rd(30'h0000_0031, 5'h04);
        // R2: writes to live and gated views dropped
        wr(30'h0000_0010, 5'h04, 32'hFFFF_FFFF);
        wr(30'h0000_0010, 5'h08, 32'hFFFF_FFFF);
        rd(30'h0000_0010, 5'h04); rd(30'h0000_0010, 5'h08);
        // R8: narrow accesses
        step(30'h10, 1'b1, 1'b0, 2'b00, 5'h00, 32'hFFFF_FFFF);
        step(30'h10, 1'b1, 1'b0, 2'b01, 5'h0C, 32'h1234_5678);
        step(30'h10, 1'b0, 1'b1, 2'b00, 5'h00, 32'h0);
        step(30'h10, 1'b0, 1'b1, 2'b11, 5'h16, 32'h0);
        rd(30'h10, 5'h00); rd(30'h10, 5'h0C);
        // R9: out-of-map and unaligned accesses
        wr(30'h10, 5'h14, 32'hFFFF_FFFF);
        wr(30'h10, 5'h02, 32'hFFFF_FFFF);
        rd(30'h10, 5'h1C); rd(30'h10, 5'h09);
        rd(30'h10, 5'h00);
        // R11: status words hold 32 bits
        wr(30'h10, 5'h0C, 32'hDEAD_BEEF); wr(30'h10, 5'h10, 32'hC001_F00D);
        rd(30'h10, 5'h0C); rd(30'h10, 5'h10);
        // R6: everything quiet
        idle('0); idle('0);
        // Mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[3:0] == 0) ? 30'($urandom) : (30'h1 << ($urandom % 30)) & 30'($urandom | 32'h1),
                 r[4] & r[5], r[6], (r[9:7] == 0) ? 2'(r[11:10]) : 2'b10,
                 (r[13:12] == 0) ? 5'($urandom) : 5'(($urandom % 5) * 4), $urandom);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule